// File: doc/BRIEF.md
# Vertical Sync and Field Detector

This block takes an active-low composite sync signal that is already synchronised to the local clock. From it, the block produces three outputs: an active-low vertical sync pulse, an odd/even field flag and a flag that reports loss of sync. All timing is counted in clock cycles. Every threshold is a parameter, so one design covers both broadcast line rates and faster scan rates.

Low pulses shorter than a minimum width are treated as noise and dropped before anything else looks at them. Pulses that pass are sorted by width into three classes: narrow (line or equalising pulses), serrated vertical pulses, and over-long lows. A vertical interval with serrations starts the output at the trailing edge of its first serrated pulse. The output ends at the trailing edge of the first narrow pulse that follows. A vertical interval with no serrations is a single long low. For that case, a fixed-length default pulse is issued instead.

The field flag is set from the line phase at which the vertical interval begins. That phase is measured from the last pulse accepted as a horizontal edge; half-line pulses are not accepted as horizontal edges. A watchdog raises the loss flag when no valid pulse has arrived for a long stretch. The next valid pulse clears it.

Top module: `vsync_field_detector`

## Requirements
- R1: While reset is held, `vsync_n` is 1, `field_odd` is 0 and `no_signal` is 1.
- R2: A low pulse shorter than `MIN_W` cycles has no effect on any output and does not count as sync activity.
- R3: A pulse is serrated when its low width W satisfies `BROAD_TH` < W < `DEF_TH`. When idle, `vsync_n` goes low after the clock edge at which the input is first sampled high at the end of a serrated pulse.
- R4: Once a serrated vertical has started, `vsync_n` returns high after the clock edge at which the input is first sampled high at the end of a narrow pulse. A narrow pulse has `MIN_W` <= W <= `BROAD_TH`. Further serrated pulses do not end it.
- R5: When idle, a low run reaching `DEF_TH` cycles drives `vsync_n` low after the edge of its `DEF_TH`-th low sample, for exactly `DEF_LEN` cycles. The trailing edge of that long low starts nothing.
- R6: At a serrated start, `field_odd` becomes 1 if at least `LINE_CYC`/2 cycles have elapsed since the last horizontal edge, and 0 otherwise. A default pulse and all other events leave it unchanged.
- R7: A horizontal edge is the `MIN_W`-th low sample of a pulse, taken only if at least 3·`LINE_CYC`/4 cycles have elapsed since the previous horizontal edge. Half-line pulses are therefore not horizontal edges.
- R8: `no_signal` rises `TIMEOUT` cycles after the last accepted pulse (counted at its `MIN_W`-th low sample). It falls after the edge of the next accepted pulse.
- R9: A cycle after `no_signal` is seen high, `vsync_n` is forced high and vertical detection returns to idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| csync_n | input | 1 | Synchronised composite sync, active low |
| vsync_n | output | 1 | Vertical sync pulse, active low |
| field_odd | output | 1 | 1 for odd field, 0 for even field |
| no_signal | output | 1 | High when sync activity has stopped |

## Verification
Corrupted internal state shows up at the ports within one or two clocks.

- A low-width counter that is off by one moves the start or end of the vertical pulse by a cycle.
- A stuck FSM state holds `vsync_n` low past the first narrow pulse.
- A horizontal-phase counter that resets on half-line pulses inverts `field_odd` at the next serrated vertical.
- A watchdog off by one moves the `no_signal` rise by exactly one cycle.

Each of these is caught by the per-clock comparison against the behavioural model, on the very clock where the outputs diverge.

// File: rtl/vfd_pkg.sv
// Shared types for the vertical sync and field detector.
package vfd_pkg;

    // Vertical detection state: idle, inside a serrated interval, or
    // timing a default pulse.
    typedef enum logic [1:0] {
        V_IDLE = 2'd0,
        V_SERR = 2'd1,
        V_DEF  = 2'd2
    } vstate_t;

endpackage

// File: rtl/vfd_pulse_meas.sv
// Low-pulse width classifier.
// Counts the current low run of csync_n and raises single-cycle events:
// accepted pulse (MIN_W-th low sample), over-long low (DEF_TH-th low
// sample), and, on the first high sample, the class of the pulse just
// ended. Assumes csync_n is already synchronised to clk and that
// 1 <= MIN_W <= BROAD_TH < DEF_TH.
module vfd_pulse_meas #(
    parameter int MIN_W    = 27,
    parameter int BROAD_TH = 270,
    parameter int DEF_TH   = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic csync_n,
    output logic lead_ok,
    output logic long_hit,
    output logic trail_serr,
    output logic trail_eq
);
    localparam int CW = $clog2(DEF_TH + 1);
    localparam logic [CW-1:0] K_MIN_M1 = CW'(MIN_W - 1);
    localparam logic [CW-1:0] K_MIN    = CW'(MIN_W);
    localparam logic [CW-1:0] K_BROAD  = CW'(BROAD_TH);
    localparam logic [CW-1:0] K_DEF    = CW'(DEF_TH);
    localparam logic [CW-1:0] K_DEF_M1 = CW'(DEF_TH - 1);

    logic [CW-1:0] low_cnt;

    // Length of the current low run, saturating at DEF_TH.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            low_cnt <= '0;
        end else if (csync_n) begin
            low_cnt <= '0;
        end else if (low_cnt != K_DEF) begin
            low_cnt <= low_cnt + 1'b1;
        end
    end

    // Events while low: acceptance point and over-long point.
    always_comb begin
        lead_ok  = !csync_n && (low_cnt == K_MIN_M1);
        long_hit = !csync_n && (low_cnt == K_DEF_M1);
    end

    // Events at the trailing edge: pulse class by finished width.
    always_comb begin
        trail_serr = csync_n && (low_cnt > K_BROAD) && (low_cnt < K_DEF);
        trail_eq   = csync_n && (low_cnt >= K_MIN) && (low_cnt <= K_BROAD);
    end

    // A classified trailing edge is always preceded by a low sample.
    AST_TRAIL_AFTER_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (trail_serr || trail_eq) |-> !$past(csync_n)); // R2

endmodule

// File: rtl/vfd_field_track.sv
// Line-phase tracker and field flag.
// Keeps the cycles elapsed since the last horizontal edge; a pulse is a
// horizontal edge only if it comes at least 3/4 of a line after the
// previous one, so half-line pulses are skipped. At a serrated vertical
// start the flag records whether the start lies in the second half of
// the line. Assumes LINE_CYC >= 4.
module vfd_field_track #(
    parameter int LINE_CYC = 1716
) (
    input  logic clk,
    input  logic rst_n,
    input  logic lead_ok,
    input  logic serr_onset,
    output logic field_odd
);
    localparam int HW = $clog2(LINE_CYC + 1);
    localparam logic [HW-1:0] K_MAX  = HW'(LINE_CYC);
    localparam logic [HW-1:0] K_HMIN = HW'((LINE_CYC * 3) / 4);
    localparam logic [HW-1:0] K_HALF = HW'(LINE_CYC / 2);

    logic [HW-1:0] hcount;
    logic          h_edge;

    // A pulse counts as horizontal only when spaced a near-full line.
    always_comb begin
        h_edge = lead_ok && (hcount >= K_HMIN);
    end

    // Cycles since the last horizontal edge, saturating at one line.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hcount <= K_MAX;
        end else if (h_edge) begin
            hcount <= '0;
        end else if (hcount != K_MAX) begin
            hcount <= hcount + 1'b1;
        end
    end

    // Field flag sampled from the line phase at a serrated start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            field_odd <= 1'b0;
        end else if (serr_onset) begin
            field_odd <= (hcount >= K_HALF);
        end
    end

    AST_FIELD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(field_odd) |-> $past(serr_onset)); // R6

endmodule

// File: rtl/vfd_activity_wd.sv
// Sync-activity watchdog.
// Counts cycles since the last accepted pulse; raises no_sig once the
// count reaches TIMEOUT and drops it at the next accepted pulse. Comes
// out of reset flagged, since no sync has yet been seen. Assumes
// TIMEOUT >= 2.
module vfd_activity_wd #(
    parameter int TIMEOUT = 16200
) (
    input  logic clk,
    input  logic rst_n,
    input  logic lead_ok,
    output logic no_sig
);
    localparam int TW = $clog2(TIMEOUT + 1);
    localparam logic [TW-1:0] K_LAST = TW'(TIMEOUT - 1);

    logic [TW-1:0] idle_cnt;

    // Idle-time counter and the loss flag it drives.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idle_cnt <= '0;
            no_sig   <= 1'b1;
        end else if (lead_ok) begin
            idle_cnt <= '0;
            no_sig   <= 1'b0;
        end else if (idle_cnt == K_LAST) begin
            no_sig   <= 1'b1;
        end else begin
            idle_cnt <= idle_cnt + 1'b1;
        end
    end

    AST_NOSIG_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        lead_ok |=> !no_sig); // R8

    AST_NOSIG_RISE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(no_sig) |-> !$past(lead_ok)); // R8

endmodule

// File: rtl/vfd_vert_fsm.sv
// Vertical pulse sequencer.
// From idle, a serrated trailing edge opens a vertical that closes at the
// next narrow trailing edge; an over-long low opens a default pulse of
// DEF_LEN cycles. Loss of sync forces idle. Assumes DEF_LEN >= 1.
module vfd_vert_fsm
    import vfd_pkg::*;
#(
    parameter int DEF_LEN = 5265
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trail_serr,
    input  logic trail_eq,
    input  logic long_hit,
    input  logic no_sig,
    output logic vsync_n,
    output logic serr_onset
);
    localparam int DW = $clog2(DEF_LEN + 1);
    localparam logic [DW-1:0] K_DLAST = DW'(DEF_LEN - 1);

    vstate_t       state;
    logic [DW-1:0] dcnt;

    // Serrated start event, shared with the field tracker.
    always_comb begin
        serr_onset = (state == V_IDLE) && trail_serr && !no_sig;
    end

    // State, output and default-length counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= V_IDLE;
            vsync_n <= 1'b1;
            dcnt    <= '0;
        end else if (no_sig) begin
            state   <= V_IDLE;
            vsync_n <= 1'b1;
        end else begin
            case (state)
                V_IDLE: begin
                    if (trail_serr) begin
                        state   <= V_SERR;
                        vsync_n <= 1'b0;
                    end else if (long_hit) begin
                        state   <= V_DEF;
                        vsync_n <= 1'b0;
                        dcnt    <= '0;
                    end
                end
                V_SERR: begin
                    if (trail_eq) begin
                        state   <= V_IDLE;
                        vsync_n <= 1'b1;
                    end
                end
                V_DEF: begin
                    if (dcnt == K_DLAST) begin
                        state   <= V_IDLE;
                        vsync_n <= 1'b1;
                    end else begin
                        dcnt <= dcnt + 1'b1;
                    end
                end
                default: begin
                    state   <= V_IDLE;
                    vsync_n <= 1'b1;
                end
            endcase
        end
    end

    AST_VS_FALL_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(vsync_n) |-> $past(trail_serr || long_hit)); // R3

    AST_NOSIG_FORCES_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (no_sig && $past(no_sig)) |-> vsync_n); // R9

    AST_DEF_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        (state == V_DEF) |-> (dcnt <= K_DLAST)); // R5

endmodule

// File: rtl/vsync_field_detector.sv
// Vertical sync and field detector, top level.
// Takes a synchronised active-low composite sync and produces a vertical
// sync pulse, an odd/even field flag and a loss-of-sync flag. All
// thresholds are in clock cycles. Assumes
// MIN_W <= BROAD_TH < DEF_TH and that a serrated pulse is wider than
// BROAD_TH but narrower than DEF_TH.
module vsync_field_detector #(
    parameter int LINE_CYC = 1716,
    parameter int MIN_W    = 27,
    parameter int BROAD_TH = 270,
    parameter int DEF_TH   = 1000,
    parameter int DEF_LEN  = 5265,
    parameter int TIMEOUT  = 16200
) (
    input  logic clk,
    input  logic rst_n,
    input  logic csync_n,
    output logic vsync_n,
    output logic field_odd,
    output logic no_signal
);
    logic lead_ok;
    logic long_hit;
    logic trail_serr;
    logic trail_eq;
    logic serr_onset;

    vfd_pulse_meas #(
        .MIN_W   (MIN_W),
        .BROAD_TH(BROAD_TH),
        .DEF_TH  (DEF_TH)
    ) u_meas (
        .clk       (clk),
        .rst_n     (rst_n),
        .csync_n   (csync_n),
        .lead_ok   (lead_ok),
        .long_hit  (long_hit),
        .trail_serr(trail_serr),
        .trail_eq  (trail_eq)
    );

    vfd_activity_wd #(
        .TIMEOUT(TIMEOUT)
    ) u_wd (
        .clk    (clk),
        .rst_n  (rst_n),
        .lead_ok(lead_ok),
        .no_sig (no_signal)
    );

    vfd_vert_fsm #(
        .DEF_LEN(DEF_LEN)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .trail_serr(trail_serr),
        .trail_eq  (trail_eq),
        .long_hit  (long_hit),
        .no_sig    (no_signal),
        .vsync_n   (vsync_n),
        .serr_onset(serr_onset)
    );

    vfd_field_track #(
        .LINE_CYC(LINE_CYC)
    ) u_field (
        .clk       (clk),
        .rst_n     (rst_n),
        .lead_ok   (lead_ok),
        .serr_onset(serr_onset),
        .field_odd (field_odd)
    );

endmodule

// File: tb/tb_vsync_field_detector.sv
module tb_vsync_field_detector;
    localparam int LINE = 64;
    localparam int MINW = 3;
    localparam int BRD  = 12;
    localparam int DTH  = 40;
    localparam int DLEN = 100;
    localparam int TOUT = 300;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic csync_n = 1'b1;
    logic vsync_n, field_odd, no_signal;

    always #5 clk = ~clk;

    vsync_field_detector #(
        .LINE_CYC(LINE), .MIN_W(MINW), .BROAD_TH(BRD),
        .DEF_TH(DTH), .DEF_LEN(DLEN), .TIMEOUT(TOUT)
    ) dut (
        .clk(clk), .rst_n(rst_n), .csync_n(csync_n),
        .vsync_n(vsync_n), .field_odd(field_odd), .no_signal(no_signal)
    );

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;

    // Behavioural reference: timestamps of events, updated each edge.
    int  t = 0, run = 0, last_h = -1000000, last_lead = -1;
    int  mode = 0, dleft = 0;
    bit  e_vs = 1'b1, e_odd = 1'b0, e_ns = 1'b1;

    always @(posedge clk) begin
        if (!rst_n) begin
            t = 0; run = 0; last_h = -1000000; last_lead = -1;
            mode = 0; dleft = 0; e_vs = 1'b1; e_odd = 1'b0; e_ns = 1'b1;
        end else begin
            bit ld, lg, ser, eq;
            int since;
            ld = 0; lg = 0; ser = 0; eq = 0;
            if (!csync_n) begin
                run = run + 1;
                ld = (run == MINW);
                lg = (run == DTH);
            end else begin
                ser = (run > BRD) && (run < DTH);
                eq  = (run >= MINW) && (run <= BRD);
                run = 0;
            end
            since = t - last_h - 1;
            if (e_ns) begin
                mode = 0; e_vs = 1'b1;
            end else if (mode == 0) begin
                if (ser) begin
                    mode = 1; e_vs = 1'b0; e_odd = (since >= LINE / 2);
                end else if (lg) begin
                    mode = 2; e_vs = 1'b0; dleft = DLEN - 1;
                end
            end else if (mode == 1) begin
                if (eq) begin mode = 0; e_vs = 1'b1; end
            end else begin
                if (dleft == 0) begin mode = 0; e_vs = 1'b1; end
                else dleft = dleft - 1;
            end
            if (ld && since >= (LINE * 3) / 4) last_h = t;
            if (ld) last_lead = t;
            e_ns = (last_lead < 0) ? 1'b1 : ((t - last_lead) >= TOUT);
            t = t + 1;
        end
    end

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    // Per-clock comparison, pulse monitor and watchdog.
    int vs_falls = 0, low_len = 0, last_low_len = 0;
    bit vs_prev = 1'b1;
    always @(negedge clk) begin
        cyc = cyc + 1;
        if (cyc > 150000) begin
            n_fail = n_fail + 1;
            $display("FAIL watchdog expired: actual %0d cycles, expected < 150000", cyc);
            finish_run();
        end
        if (rst_n) begin
            n_chk = n_chk + 3;
            if (vsync_n !== e_vs) begin
                n_fail = n_fail + 1;
                $display("FAIL R3 R4 R5 R9 vsync_n at cycle %0d: actual %b expected %b", cyc, vsync_n, e_vs);
            end
            if (field_odd !== e_odd) begin
                n_fail = n_fail + 1;
                $display("FAIL R6 R7 field_odd at cycle %0d: actual %b expected %b", cyc, field_odd, e_odd);
            end
            if (no_signal !== e_ns) begin
                n_fail = n_fail + 1;
                $display("FAIL R8 no_signal at cycle %0d: actual %b expected %b", cyc, no_signal, e_ns);
            end
            if (vs_prev && !vsync_n) vs_falls = vs_falls + 1;
            if (!vsync_n) low_len = low_len + 1;
            else if (!vs_prev) begin last_low_len = low_len; low_len = 0; end
            vs_prev = vsync_n;
        end
    end

    task automatic chk(bit ok, string req, int act, int exp);
        n_chk = n_chk + 1;
        if (!ok) begin
            n_fail = n_fail + 1;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic pulse(int lo, int hi);
        csync_n = 1'b0;
        repeat (lo) @(negedge clk);
        csync_n = 1'b1;
        repeat (hi) @(negedge clk);
    endtask

    task automatic lines(int n);
        for (int i = 0; i < n; i++) pulse(5, LINE - 5);
    endtask

    task automatic vert(bit shift);
        if (shift) pulse(5, LINE / 2 - 5);
        for (int i = 0; i < 6; i++) pulse(4, LINE / 2 - 4);
        for (int i = 0; i < 6; i++) pulse(27, LINE / 2 - 27);
        for (int i = 0; i < 6; i++) pulse(4, LINE / 2 - 4);
    endtask

    initial begin
        int f0, fa, fb;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(vsync_n === 1'b1, "R1 vsync_n in reset", vsync_n, 1);
        chk(field_odd === 1'b0, "R1 field_odd in reset", field_odd, 0);
        chk(no_signal === 1'b1, "R1 no_signal in reset", no_signal, 1);
        rst_n = 1'b1;
        @(negedge clk);

        // R8: first valid pulse clears loss flag
        lines(10);
        chk(no_signal === 1'b0, "R8 no_signal after sync", no_signal, 0);

        // R2: glitches between lines start nothing
        f0 = vs_falls;
        for (int i = 0; i < 10; i++) begin pulse(2, 30); pulse(5, 27); end
        chk(vs_falls == f0, "R2 glitch vertical count", vs_falls - f0, 0);

        // R3 R4 R6 R7: serrated vertical, field A
        lines(5);
        f0 = vs_falls;
        vert(1'b0);
        fa = field_odd;
        chk(vs_falls - f0 == 1, "R3 R4 one vertical in field A", vs_falls - f0, 1);
        chk(vsync_n === 1'b1, "R4 vertical ended in field A", vsync_n, 1);
        lines(8);
        // field B, shifted by half a line
        f0 = vs_falls;
        vert(1'b1);
        fb = field_odd;
        chk(vs_falls - f0 == 1, "R3 R4 one vertical in field B", vs_falls - f0, 1);
        chk(fa != fb, "R6 R7 fields A and B differ", fb, 1 - fa);
        chk(fa == 0 && fb == 1, "R6 field parity values", fa * 2 + fb, 1);
        lines(8);

        // R5: default vertical with no serrations
        f0 = vs_falls;
        pulse(150, LINE - 6);
        lines(3);
        chk(vs_falls - f0 == 1, "R5 one default vertical", vs_falls - f0, 1);
        chk(last_low_len == DLEN, "R5 default length", last_low_len, DLEN);
        chk(field_odd == fb, "R6 default leaves field", field_odd, fb);

        // R8: silence raises loss flag; glitches do not clear it (R2)
        lines(2);
        csync_n = 1'b1;
        repeat (TOUT + 5) @(negedge clk);
        chk(no_signal === 1'b1, "R8 no_signal after silence", no_signal, 1);
        for (int i = 0; i < 5; i++) pulse(2, 20);
        chk(no_signal === 1'b1, "R2 glitch keeps no_signal", no_signal, 1);
        lines(2);
        chk(no_signal === 1'b0, "R8 no_signal cleared", no_signal, 0);

        // R9: vertical open when sync stops is forced closed
        lines(3);
        pulse(27, 5);
        chk(vsync_n === 1'b0, "R3 vertical open", vsync_n, 0);
        csync_n = 1'b1;
        repeat (TOUT + 5) @(negedge clk);
        chk(vsync_n === 1'b1, "R9 vertical closed by loss", vsync_n, 1);
        lines(4);
        chk(vsync_n === 1'b1, "R9 idle after recovery", vsync_n, 1);

        repeat (5) @(negedge clk);
        finish_run();
    end
endmodule